// File: doc/BRIEF.md
# Triple-Sampling Serial Receiver with Noise Detection

This block is the receive half of an asynchronous serial port. The raw line first passes through a synchronizer. The block then examines the line only on cycles that carry an enable tick, which the surrounding logic issues at sixteen times the bit rate; a 57600 bit/s link is the usual setting. Each character has a low start bit, eight data bits sent least significant bit first, a parity bit when parity is enabled, and a high stop bit. The block takes three samples of every bit, on the ticks just before, at and just after the bit centre.

The three samples are not resolved by a majority vote. The middle sample supplies the bit value. If the three samples of any bit in the character disagree, including the start and stop bits, the noise flag is raised for that character. The received byte and its three error flags are published together with a one-cycle valid strobe when the stop bit ends. They then hold until the next character. Parity can be turned on or off, and its sense chosen, through two static configuration inputs.

Top module: `rx_tri_uart`

## Requirements
- R1: While reset is asserted and after it is released, valid_o, data_o (0x00) and all three error flags are low until a character completes.
- R2: A character starts on a tick that sees the synchronized line low when the previous tick saw it high. That tick is phase 0 of the start bit. Each bit lasts 16 ticks, and its samples are taken on phases 7, 8 and 9. Disturbances on any other phase have no effect.
- R3: If the phase 8 sample of the start bit is high, the character is abandoned without a valid strobe, and data_o and the flags keep their previous values.
- R4: The eight data bits are assembled least significant bit first. Each bit's value is its phase 8 sample, even when its other samples disagree.
- R5: valid_o is high for exactly one clock, one clock after the tick at phase 15 of the stop bit. It is raised once per accepted character.
- R6: With par_en_i=1, one parity bit follows the data. par_odd_i=0 selects even parity, so the error is raised when data and parity hold an odd number of ones. par_odd_i=1 selects odd parity, so the error is raised when they hold an even number of ones. With par_en_i=0 there is no parity bit and parity_err_o is 0.
- R7: frame_err_o is 1 exactly when all three stop-bit samples are low.
- R8: noise_err_o is 1 when, for any bit of the character (start, data, parity or stop), the three samples are not all equal.
- R9: data_o and the three flags change only on the clock where valid_o is high.
- R10: The line is ignored on cycles without a tick. A one-clock glitch away from a tick changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Raw serial line, idle high |
| tick16_i | input | 1 | Enable pulse at sixteen times the bit rate |
| par_en_i | input | 1 | 1 = a parity bit follows the data |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| data_o | output | 8 | Last received byte |
| valid_o | output | 1 | One-cycle strobe for a completed character |
| parity_err_o | output | 1 | Parity mismatch in the last character |
| frame_err_o | output | 1 | Stop bit read low on all three samples |
| noise_err_o | output | 1 | Some bit's three samples disagreed |

## Verification
The hardest cases to reach are single-tick disturbances that land exactly on one of the three sample phases of a chosen bit, or just outside them. Examples are a flipped middle sample inside the data, a lone low sample in the stop bit, and a dip in the start bit that ends before the centre. The stimulus therefore drives the line tick by tick, and each tick's value is chosen per bit and per phase. This places flips on phases 6, 7, 8, 9 and 10 of start, data and stop bits. A further frame adds one-clock glitches between ticks.

// File: rtl/rx_tri_pkg.sv
package rx_tri_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/rx_tri_sync.sv
module rx_tri_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b1;
      else if (g == 0) chain_q[g] <= d_i;
      else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rx_tri_sampler.sv
module rx_tri_sampler #(
  parameter int unsigned OVS = 16,
  parameter int unsigned MID = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic line_i,
  input  logic start_i,
  input  logic run_i,
  output logic eval_o,
  output logic mid_o,
  output logic noisy_o,
  output logic trio_low_o,
  output logic bit_end_o
);
  localparam int unsigned PH_W   = $clog2(OVS);
  localparam int unsigned NSAMP  = 3;
  localparam int unsigned WIN_LO = MID - 1;
  localparam int unsigned WIN_HI = MID + 1;

  logic [PH_W-1:0]  phase_q;
  logic [NSAMP-2:0] samp_q;
  logic [NSAMP-1:0] trio;
  logic             step, in_win;

  assign step   = tick_i && run_i;
  assign in_win = (phase_q >= PH_W'(WIN_LO)) && (phase_q < PH_W'(WIN_HI));
  // trio[NSAMP-1] is the earliest sample, trio[0] the current line
  assign trio   = {samp_q, line_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      samp_q  <= '0;
    end else begin
      if (start_i) phase_q <= PH_W'(1);
      else if (step) phase_q <= (phase_q == PH_W'(OVS-1)) ? '0 : phase_q + 1'b1;
      if (step && in_win) samp_q <= {samp_q[NSAMP-3:0], line_i};
    end
  end

  assign eval_o     = step && (phase_q == PH_W'(WIN_HI));
  assign bit_end_o  = step && (phase_q == PH_W'(OVS-1));
  assign mid_o      = trio[NSAMP/2];
  assign trio_low_o = ~|trio;
  assign noisy_o    = ~((&trio) | (~|trio));
endmodule

// File: rtl/rx_tri_framer.sv
module rx_tri_framer
  import rx_tri_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              eval_i,
  input  logic              mid_i,
  input  logic              noisy_i,
  input  logic              trio_low_i,
  input  logic              bit_end_i,
  output logic              start_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              parity_err_o,
  output logic              frame_err_o,
  output logic              noise_err_o
);
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  rx_state_e          state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [DATA_W-1:0]  shift_q, data_q;
  logic               line_prev_q, pbit_q, stop_low_q, noise_acc_q;
  logic               valid_q, perr_q, ferr_q, nerr_q;

  assign start_o = (state_q == ST_IDLE) && tick_i && !line_i && line_prev_q;
  assign busy_o  = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      shift_q     <= '0;
      data_q      <= '0;
      line_prev_q <= 1'b1;
      pbit_q      <= 1'b0;
      stop_low_q  <= 1'b0;
      noise_acc_q <= 1'b0;
      valid_q     <= 1'b0;
      perr_q      <= 1'b0;
      ferr_q      <= 1'b0;
      nerr_q      <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (tick_i) line_prev_q <= line_i;
      unique case (state_q)
        ST_IDLE: begin
          if (start_o) begin
            state_q     <= ST_START;
            cnt_q       <= '0;
            noise_acc_q <= 1'b0;
            pbit_q      <= 1'b0;
          end
        end
        ST_START: begin
          if (eval_i) begin
            if (mid_i) state_q <= ST_IDLE;  // false start
            else noise_acc_q <= noisy_i;
          end else if (bit_end_i) begin
            state_q <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (eval_i) begin
            shift_q     <= {mid_i, shift_q[DATA_W-1:1]};
            noise_acc_q <= noise_acc_q | noisy_i;
          end else if (bit_end_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(DATA_W-1)) state_q <= par_en_i ? ST_PAR : ST_STOP;
          end
        end
        ST_PAR: begin
          if (eval_i) begin
            pbit_q      <= mid_i;
            noise_acc_q <= noise_acc_q | noisy_i;
          end else if (bit_end_i) begin
            state_q <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (eval_i) begin
            stop_low_q  <= trio_low_i;
            noise_acc_q <= noise_acc_q | noisy_i;
          end else if (bit_end_i) begin
            state_q <= ST_IDLE;
            valid_q <= 1'b1;
            data_q  <= shift_q;
            perr_q  <= par_en_i && ((^shift_q) ^ pbit_q ^ par_odd_i);
            ferr_q  <= stop_low_q;
            nerr_q  <= noise_acc_q;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign data_o       = data_q;
  assign valid_o      = valid_q;
  assign parity_err_o = perr_q;
  assign frame_err_o  = ferr_q;
  assign noise_err_o  = nerr_q;
endmodule

// File: rtl/rx_tri_uart.sv
module rx_tri_uart #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned OVS         = 16,
  parameter int unsigned MID         = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic              tick16_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              parity_err_o,
  output logic              frame_err_o,
  output logic              noise_err_o
);
  logic line_s, start, busy, eval, mid, noisy, trio_low, bit_end;

  rx_tri_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (line_s)
  );

  rx_tri_sampler #(.OVS(OVS), .MID(MID)) u_samp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick16_i),
    .line_i    (line_s),
    .start_i   (start),
    .run_i     (busy),
    .eval_o    (eval),
    .mid_o     (mid),
    .noisy_o   (noisy),
    .trio_low_o(trio_low),
    .bit_end_o (bit_end)
  );

  rx_tri_framer #(.DATA_W(DATA_W)) u_frm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick16_i),
    .line_i      (line_s),
    .par_en_i    (par_en_i),
    .par_odd_i   (par_odd_i),
    .eval_i      (eval),
    .mid_i       (mid),
    .noisy_i     (noisy),
    .trio_low_i  (trio_low),
    .bit_end_i   (bit_end),
    .start_o     (start),
    .busy_o      (busy),
    .data_o      (data_o),
    .valid_o     (valid_o),
    .parity_err_o(parity_err_o),
    .frame_err_o (frame_err_o),
    .noise_err_o (noise_err_o)
  );
endmodule

// File: rtl/rx_tri_chk.sv
module rx_tri_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick16_i,
  input logic              par_en_i,
  input logic              busy_i,
  input logic              valid_i,
  input logic [DATA_W-1:0] data_i,
  input logic              perr_i,
  input logic              ferr_i,
  input logic              nerr_i
);
  p_valid_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  p_valid_after_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $past(tick16_i));

  p_valid_ends_frame_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ($past(busy_i) && !busy_i));

  p_data_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> $stable(data_i));

  p_flag_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> $stable({perr_i, ferr_i, nerr_i}));

  p_par_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !par_en_i) |-> !perr_i);
endmodule

bind rx_tri_uart rx_tri_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick16_i(tick16_i),
  .par_en_i(par_en_i),
  .busy_i  (busy),
  .valid_i (valid_o),
  .data_i  (data_o),
  .perr_i  (parity_err_o),
  .ferr_i  (frame_err_o),
  .nerr_i  (noise_err_o)
);

// File: tb/rx_tri_uart_tb_top.sv
module rx_tri_uart_tb_top;
  logic clk_i = 1'b0;
  always #2 clk_i = ~clk_i;

  logic       rst_ni = 1'b0;
  logic       rxd_r = 1'b1, tick_r = 1'b0, pe_r = 1'b0, po_r = 1'b0;
  logic [7:0] data_o;
  logic       valid_o, parity_err_o, frame_err_o, noise_err_o;

  rx_tri_uart dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .rxd_i(rxd_r), .tick16_i(tick_r),
    .par_en_i(pe_r), .par_odd_i(po_r), .data_o(data_o), .valid_o(valid_o),
    .parity_err_o(parity_err_o), .frame_err_o(frame_err_o), .noise_err_o(noise_err_o)
  );

  int checks = 0, fails = 0, vcount = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // behavioural reference: tick-level view of the line, sample queue per frame
  bit         m_busy, m_prev;
  int         m_t, m_nb, m_ph;
  bit         m_q[$];
  logic       e_valid, e_pe, e_fe, e_ne;
  logic [7:0] e_data;

  task automatic model_close();
    int s;
    e_ne = 1'b0;
    for (int k = 0; k < m_nb; k++)
      if (!(m_q[3*k] == m_q[3*k+1] && m_q[3*k+1] == m_q[3*k+2])) e_ne = 1'b1;
    for (int i = 0; i < 8; i++) e_data[i] = m_q[3*(i+1)+1];
    e_pe = pe_r ? ((^e_data) ^ m_q[3*9+1] ^ po_r) : 1'b0;
    s = 3*(m_nb-1);
    e_fe = !m_q[s] && !m_q[s+1] && !m_q[s+2];
    e_valid = 1'b1;
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_prev = 1; m_t = 0; m_nb = 10; m_ph = 0;
      e_valid = 0; e_data = 0; e_pe = 0; e_fe = 0; e_ne = 0;
      m_q.delete();
    end else begin
      e_valid = 1'b0;
      if (tick_r) begin
        if (m_busy) begin
          m_ph = m_t % 16;
          if (m_ph >= 7 && m_ph <= 9) m_q.push_back(rxd_r);
          if (m_t == 9 && m_q[1]) m_busy = 0;
          else if (m_t == m_nb*16-1) begin model_close(); m_busy = 0; end
          m_t++;
        end else if (!rxd_r && m_prev) begin
          m_busy = 1; m_t = 1; m_q.delete(); m_nb = pe_r ? 11 : 10;
        end
        m_prev = rxd_r;
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (valid_o === 1'b1) vcount++;
      chk("R5 valid_o vs model", valid_o, e_valid);
      chk("R4 data_o vs model", data_o, e_data);
      chk("R6 parity_err_o vs model", parity_err_o, e_pe);
      chk("R7 frame_err_o vs model", frame_err_o, e_fe);
      chk("R8 noise_err_o vs model", noise_err_o, e_ne);
    end
  end

  // one tick step: 4 clocks, line set 3 clocks ahead of the tick
  task automatic tick_step(input logic v, input bit glitch);
    @(negedge clk_i);
    tick_r = 1'b0;
    rxd_r  = glitch ? ~v : v;
    @(negedge clk_i);
    rxd_r = v;
    @(negedge clk_i);
    @(negedge clk_i);
    tick_r = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick_step(1'b1, 1'b0);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit pe, input bit po, input bit pflip,
                            input int nz_bit, input int nz_ph, input bit stop_lo,
                            input bit glitch, input int pre);
    logic bits [0:10];
    int   nb;
    logic v;
    pe_r = pe; po_r = po;
    idle(pre);
    nb = pe ? 11 : 10;
    bits[0] = 1'b0;
    for (int i = 0; i < 8; i++) bits[1+i] = d[i];
    if (pe) bits[9] = (^d) ^ po ^ pflip;
    bits[nb-1] = stop_lo ? 1'b0 : 1'b1;
    for (int b = 0; b < nb; b++)
      for (int ph = 0; ph < 16; ph++) begin
        v = bits[b];
        if (b == nz_bit && ph == nz_ph) v = ~v;
        tick_step(v, glitch && ph == 3);
      end
  endtask

  task automatic expect_char(input string tag, input logic [7:0] d, input logic pe,
                             input logic fe, input logic ne);
    idle(2);
    chk({tag, " data"}, data_o, d);
    chk({tag, " R6 parity"}, parity_err_o, pe);
    chk({tag, " R7 framing"}, frame_err_o, fe);
    chk({tag, " R8 noise"}, noise_err_o, ne);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset valid", valid_o, 0);
    chk("R1 reset data", data_o, 0);
    chk("R1 reset flags", {parity_err_o, frame_err_o, noise_err_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R1 after release", {valid_o, data_o, parity_err_o, frame_err_o, noise_err_o}, 0);

    send_frame(8'hA5, 0, 0, 0, -1, 0, 0, 0, 3);  expect_char("R2 R4 clean A5", 8'hA5, 0, 0, 0);
    send_frame(8'h3C, 1, 0, 0, -1, 0, 0, 0, 3);  expect_char("R6 even ok", 8'h3C, 0, 0, 0);
    send_frame(8'h3C, 1, 1, 0, -1, 0, 0, 0, 3);  expect_char("R6 odd ok", 8'h3C, 0, 0, 0);
    send_frame(8'h3C, 1, 1, 1, -1, 0, 0, 0, 3);  expect_char("R6 odd bad", 8'h3C, 1, 0, 0);
    send_frame(8'h3D, 1, 0, 1, -1, 0, 0, 0, 3);  expect_char("R6 even bad", 8'h3D, 1, 0, 0);
    send_frame(8'h81, 0, 0, 0, -1, 0, 0, 0, 3);  expect_char("R6 disabled", 8'h81, 0, 0, 0);
    send_frame(8'h55, 0, 0, 0, -1, 0, 1, 0, 3);  expect_char("R7 stop low", 8'h55, 0, 1, 0);
    send_frame(8'h55, 0, 0, 0, 9, 8, 0, 0, 3);   expect_char("R8 stop mid dip", 8'h55, 0, 0, 1);
    send_frame(8'h12, 0, 0, 0, 0, 7, 0, 0, 3);   expect_char("R8 start noise", 8'h12, 0, 0, 1);
    send_frame(8'hF0, 0, 0, 0, 4, 9, 0, 0, 3);   expect_char("R4 R8 late flip", 8'hF0, 0, 0, 1);
    send_frame(8'hF0, 0, 0, 0, 3, 8, 0, 0, 3);   expect_char("R4 R8 mid flip", 8'hF4, 0, 0, 1);
    send_frame(8'h0F, 0, 0, 0, 2, 6, 0, 0, 3);   expect_char("R2 phase 6 ignored", 8'h0F, 0, 0, 0);
    send_frame(8'h0E, 1, 0, 0, 5, 10, 0, 0, 3);  expect_char("R2 phase 10 ignored", 8'h0E, 0, 0, 0);

    // false start: start bit low on phases 0..5 only
    idle(4);
    for (int i = 0; i < 6; i++) tick_step(1'b0, 1'b0);
    idle(30);
    chk("R3 no strobe on false start", vcount, 13);
    chk("R3 data kept", data_o, 8'h0E);

    send_frame(8'h6B, 0, 0, 0, -1, 0, 0, 1, 3);  expect_char("R10 glitches", 8'h6B, 0, 0, 0);
    send_frame(8'hC3, 1, 0, 0, -1, 0, 0, 0, 3);
    send_frame(8'h3A, 1, 0, 0, -1, 0, 0, 0, 0);  expect_char("R5 back to back", 8'h3A, 0, 0, 0);
    idle(4);
    chk("R5 one strobe per character", vcount, 16);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL R5 watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule